// File: doc/BRIEF.md
# Memory Port Protection Rule Checker

This block sits in front of a memory controller and gives each incoming memory transaction an accept or reject verdict. A transaction is described by the megabyte page of its address, the ID of the master that issued it, the index of the port it came in on, and whether it is a secure access. The block compares the transaction against a table of protection rules. The lowest-numbered rule that matches decides the verdict. When no rule matches, a per-port default bit decides.

Software never writes the rule table directly. It fills three staging words (address span, master-ID window and attributes), then issues a write command that names a rule slot. To inspect a slot, it issues a read command, which copies that slot back into the staging words. The staging words can then be read.

Each rule covers an inclusive range of 1 MB pages and an inclusive window of master IDs. It also holds a port mask, a two-bit security enable, a valid flag and a result bit that selects accept or reject.

Top module: `mem_guard`

## Requirements
- R1: After reset every rule is invalid, the default word and every configuration register read back as 0, and every request on ports 0 to 9 is accepted.
- R2: A write to the command register (offset 0) with bit 5 set copies the three staging words into the rule whose number is in bits 4:0. Numbers 20 to 31 change no rule.
- R3: A write to the command register with bit 6 set and bit 5 clear loads the numbered rule into the staging words, zero-extended. A rule number of 20 or more loads zeros. Each configuration register can be read: offset 0 is the command, 1 the address span, 2 the ID window, 3 the attributes and 4 the default word. Read data appears one cycle after the offset is presented. The command reads back with bits 6:5 cleared.
- R4: The span word holds the low page bound in bits 11:0 and the high page bound in bits 23:12. A page matches when low <= page <= high, so both bounds are covered.
- R5: The ID word holds the low master-ID bound in bits 11:0 and the high bound in bits 23:12. Both bounds are inclusive.
- R6: Attribute word layout:
  - bits 1:0 are the security enable: bit 0 admits secure accesses and bit 1 admits non-secure accesses;
  - bit 2 is the valid flag;
  - bits 12:3 are the port mask, with bit 3+p for port p.

  A rule matches only if it is valid and the transaction's port and security state are both enabled.
- R7: Attribute bit 13 is the result: 0 accepts a matching transaction and 1 rejects it.
- R8: When several rules match, the one with the lowest number decides.
- R9: The default word (offset 4) has bit p for port p. An unmatched transaction on port p is rejected when that bit is 1 and accepted when it is 0.
- R10: A request with a port index of 10 or more is always rejected.
- R11: Every request produces resp_valid exactly one cycle later, together with the verdict. resp_reject is 0 whenever resp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, one cycle after cfg_addr |
| req_valid | input | 1 | Transaction present |
| req_page | input | 12 | Address bits 31:20 of the transaction |
| req_id | input | 12 | Master ID |
| req_port | input | 4 | Port index |
| req_secure | input | 1 | 1 for a secure access |
| resp_valid | output | 1 | Verdict present |
| resp_reject | output | 1 | 1 when the transaction is rejected |

## Verification
The assertions watch several things on every cycle:
- the one-cycle response timing and the quiet reject line while idle;
- that at most one rule wins;
- that bad port indices are rejected and unmatched requests follow the default bit;
- that out-of-range slot writes leave the table alone, and that read commands copy the selected rule into staging.

The bench sweeps pages, IDs, ports and security states against an arithmetic model under three default words. Only this sweep shows that the bound comparisons are inclusive, that a rule's fields land at the right bit positions, and that the lowest-numbered rule actually wins against real overlapping rules.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int CMD_IDX_W  = 5;
  localparam int CMD_WR_BIT = 5;
  localparam int CMD_RD_BIT = 6;
  localparam int SEC_W      = 2;

  typedef enum logic [2:0] {
    REG_CMD   = 3'd0,
    REG_SPAN  = 3'd1,
    REG_IDWIN = 3'd2,
    REG_ATTR  = 3'd3,
    REG_DFLT  = 3'd4
  } cfg_reg_e;
endpackage

// File: rtl/mg_regfile.sv
module mg_regfile import mg_pkg::*; #(
  parameter int MB_W   = 12,
  parameter int ID_W   = 12,
  parameter int ATTR_W = 14,
  parameter int CFG_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  input  logic [2*MB_W-1:0]    rd_span,
  input  logic [2*ID_W-1:0]    rd_idwin,
  input  logic [ATTR_W-1:0]    rd_attr,
  output logic [CMD_IDX_W-1:0] rule_idx,
  output logic                 wr_en,
  output logic [CFG_W-1:0]     span_q,
  output logic [CFG_W-1:0]     idwin_q,
  output logic [CFG_W-1:0]     attr_q,
  output logic [CFG_W-1:0]     dflt_q
);
  logic [CFG_W-1:0] cmd_q;
  logic             cmd_hit, rd_go;

  assign cmd_hit  = cfg_we && (cfg_addr == REG_CMD);
  assign rule_idx = cfg_wdata[CMD_IDX_W-1:0];
  assign wr_en    = cmd_hit && cfg_wdata[CMD_WR_BIT];
  assign rd_go    = cmd_hit && cfg_wdata[CMD_RD_BIT] && !cfg_wdata[CMD_WR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      span_q  <= '0;
      idwin_q <= '0;
      attr_q  <= '0;
      dflt_q  <= '0;
    end else begin
      if (cmd_hit) begin
        cmd_q <= cfg_wdata;
        cmd_q[CMD_WR_BIT] <= 1'b0;
        cmd_q[CMD_RD_BIT] <= 1'b0;
      end
      if (rd_go) begin
        span_q  <= {{(CFG_W-2*MB_W){1'b0}}, rd_span};
        idwin_q <= {{(CFG_W-2*ID_W){1'b0}}, rd_idwin};
        attr_q  <= {{(CFG_W-ATTR_W){1'b0}}, rd_attr};
      end else if (cfg_we) begin
        case (cfg_addr)
          REG_SPAN:  span_q  <= cfg_wdata;
          REG_IDWIN: idwin_q <= cfg_wdata;
          REG_ATTR:  attr_q  <= cfg_wdata;
          REG_DFLT:  dflt_q  <= cfg_wdata;
          default:   ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        REG_CMD:   cfg_rdata <= cmd_q;
        REG_SPAN:  cfg_rdata <= span_q;
        REG_IDWIN: cfg_rdata <= idwin_q;
        REG_ATTR:  cfg_rdata <= attr_q;
        REG_DFLT:  cfg_rdata <= dflt_q;
        default:   cfg_rdata <= '0;
      endcase
    end
  end

  AST_READ_LOADS_STAGE: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> (attr_q == $past({{(CFG_W-ATTR_W){1'b0}}, rd_attr}))); // R3
endmodule

// File: rtl/mg_rule_table.sv
module mg_rule_table import mg_pkg::*; #(
  parameter int NUM_RULES = 20,
  parameter int MB_W      = 12,
  parameter int ID_W      = 12,
  parameter int ATTR_W    = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [CMD_IDX_W-1:0] idx,
  input  logic [2*MB_W-1:0]    span_in,
  input  logic [2*ID_W-1:0]    idwin_in,
  input  logic [ATTR_W-1:0]    attr_in,
  output logic [2*MB_W-1:0]    rd_span,
  output logic [2*ID_W-1:0]    rd_idwin,
  output logic [ATTR_W-1:0]    rd_attr,
  output logic [2*MB_W-1:0]    span_all  [NUM_RULES],
  output logic [2*ID_W-1:0]    idwin_all [NUM_RULES],
  output logic [ATTR_W-1:0]    attr_all  [NUM_RULES]
);
  localparam int VALID_BIT = SEC_W;

  logic [NUM_RULES-1:0] valid_vec;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        span_all[g]  <= '0;
        idwin_all[g] <= '0;
        attr_all[g]  <= '0;
      end else if (wr_en && (idx == CMD_IDX_W'(g))) begin
        span_all[g]  <= span_in;
        idwin_all[g] <= idwin_in;
        attr_all[g]  <= attr_in;
      end
    end
    assign valid_vec[g] = attr_all[g][VALID_BIT];
  end

  always_comb begin
    rd_span  = '0;
    rd_idwin = '0;
    rd_attr  = '0;
    for (int i = 0; i < NUM_RULES; i++) begin
      if (idx == CMD_IDX_W'(i)) begin
        rd_span  = span_all[i];
        rd_idwin = idwin_all[i];
        rd_attr  = attr_all[i];
      end
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (valid_vec == '0)); // R1
  AST_OOR_SLOT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (idx >= CMD_IDX_W'(NUM_RULES))) |=> $stable(valid_vec)); // R2
endmodule

// File: rtl/mg_match.sv
module mg_match import mg_pkg::*; #(
  parameter int NUM_RULES = 20,
  parameter int NUM_PORTS = 10,
  parameter int PORT_W    = 4,
  parameter int MB_W      = 12,
  parameter int ID_W      = 12,
  parameter int ATTR_W    = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [MB_W-1:0]      req_page,
  input  logic [ID_W-1:0]      req_id,
  input  logic [PORT_W-1:0]    req_port,
  input  logic                 req_secure,
  input  logic [2*MB_W-1:0]    span_all  [NUM_RULES],
  input  logic [2*ID_W-1:0]    idwin_all [NUM_RULES],
  input  logic [ATTR_W-1:0]    attr_all  [NUM_RULES],
  input  logic [NUM_PORTS-1:0] dflt,
  output logic                 resp_valid,
  output logic                 resp_reject
);
  localparam int VALID_BIT = SEC_W;
  localparam int MASK_LSB  = SEC_W + 1;
  localparam int RES_BIT   = SEC_W + 1 + NUM_PORTS;

  logic [NUM_PORTS-1:0] port_oh;
  logic                 port_ok;
  logic [NUM_RULES-1:0] hit, res_vec, win;
  logic                 any_hit, rule_res, reject_d;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) port_oh[p] = (req_port == PORT_W'(p));
  end
  assign port_ok = |port_oh;

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    wire [MB_W-1:0]      pg_lo = span_all[g][MB_W-1:0];
    wire [MB_W-1:0]      pg_hi = span_all[g][2*MB_W-1:MB_W];
    wire [ID_W-1:0]      id_lo = idwin_all[g][ID_W-1:0];
    wire [ID_W-1:0]      id_hi = idwin_all[g][2*ID_W-1:ID_W];
    wire [NUM_PORTS-1:0] pmask = attr_all[g][MASK_LSB +: NUM_PORTS];
    wire                 sec_ok = req_secure ? attr_all[g][0] : attr_all[g][1];
    assign hit[g] = attr_all[g][VALID_BIT]
                 && (req_page >= pg_lo) && (req_page <= pg_hi)
                 && (req_id >= id_lo) && (req_id <= id_hi)
                 && (|(pmask & port_oh)) && sec_ok;
    assign res_vec[g] = attr_all[g][RES_BIT];
  end

  always_comb begin
    win      = '0;
    any_hit  = 1'b0;
    rule_res = 1'b0;
    for (int i = 0; i < NUM_RULES; i++) begin
      if (hit[i] && !any_hit) begin
        win[i]   = 1'b1;
        any_hit  = 1'b1;
        rule_res = res_vec[i];
      end
    end
  end

  assign reject_d = !port_ok ? 1'b1 : (any_hit ? rule_res : |(dflt & port_oh));

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_reject <= 1'b0;
    end else begin
      resp_valid  <= req_valid;
      resp_reject <= req_valid && reject_d;
    end
  end

  AST_RESP_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid); // R11
  AST_IDLE_NO_REJECT: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> !resp_reject); // R11
  AST_WINNER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win)); // R8
  AST_BAD_PORT_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !port_ok) |=> resp_reject); // R10
  AST_UNMATCHED_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && port_ok && (hit == '0)) |=> (resp_reject == $past(|(dflt & port_oh)))); // R9
endmodule

// File: rtl/mem_guard.sv
module mem_guard import mg_pkg::*; #(
  parameter int NUM_RULES = 20,
  parameter int NUM_PORTS = 10,
  parameter int MB_W      = 12,
  parameter int ID_W      = 12,
  parameter int CFG_W     = 32,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int ATTR_W   = SEC_W + NUM_PORTS + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [MB_W-1:0]   req_page,
  input  logic [ID_W-1:0]   req_id,
  input  logic [PORT_W-1:0] req_port,
  input  logic              req_secure,
  output logic              resp_valid,
  output logic              resp_reject
);
  logic [CMD_IDX_W-1:0] rule_idx;
  logic                 wr_en;
  logic [CFG_W-1:0]     span_q, idwin_q, attr_q, dflt_q;
  logic [2*MB_W-1:0]    rd_span;
  logic [2*ID_W-1:0]    rd_idwin;
  logic [ATTR_W-1:0]    rd_attr;
  logic [2*MB_W-1:0]    span_all  [NUM_RULES];
  logic [2*ID_W-1:0]    idwin_all [NUM_RULES];
  logic [ATTR_W-1:0]    attr_all  [NUM_RULES];

  mg_regfile #(.MB_W(MB_W), .ID_W(ID_W), .ATTR_W(ATTR_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_span(rd_span), .rd_idwin(rd_idwin), .rd_attr(rd_attr),
    .rule_idx(rule_idx), .wr_en(wr_en),
    .span_q(span_q), .idwin_q(idwin_q), .attr_q(attr_q), .dflt_q(dflt_q)
  );

  mg_rule_table #(.NUM_RULES(NUM_RULES), .MB_W(MB_W), .ID_W(ID_W), .ATTR_W(ATTR_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .idx(rule_idx),
    .span_in(span_q[2*MB_W-1:0]), .idwin_in(idwin_q[2*ID_W-1:0]),
    .attr_in(attr_q[ATTR_W-1:0]),
    .rd_span(rd_span), .rd_idwin(rd_idwin), .rd_attr(rd_attr),
    .span_all(span_all), .idwin_all(idwin_all), .attr_all(attr_all)
  );

  mg_match #(.NUM_RULES(NUM_RULES), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
             .MB_W(MB_W), .ID_W(ID_W), .ATTR_W(ATTR_W)) u_match (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_page(req_page),
    .req_id(req_id), .req_port(req_port), .req_secure(req_secure),
    .span_all(span_all), .idwin_all(idwin_all), .attr_all(attr_all),
    .dflt(dflt_q[NUM_PORTS-1:0]),
    .resp_valid(resp_valid), .resp_reject(resp_reject)
  );
endmodule

// File: tb/mem_guard_tb.sv
module mem_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [11:0] req_page = '0;
  logic [11:0] req_id = '0;
  logic [3:0]  req_port = '0;
  logic        req_secure = 1'b0;
  logic        resp_valid, resp_reject;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int       m_lo[20], m_hi[20], m_il[20], m_ih[20];
  bit [1:0] m_sec[20];
  bit       m_v[20], m_res[20];
  bit [9:0] m_mask[20];
  bit [9:0] m_dflt;

  always #2 clk = ~clk;

  mem_guard u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_page(req_page), .req_id(req_id),
    .req_port(req_port), .req_secure(req_secure),
    .resp_valid(resp_valid), .resp_reject(resp_reject)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic put_rule(int n, int lo, int hi, int il, int ih, bit [1:0] sec,
                          bit v, bit [9:0] mask, bit res);
    cfg_write(3'd1, 32'((hi << 12) | lo));
    cfg_write(3'd2, 32'((ih << 12) | il));
    cfg_write(3'd3, {18'd0, res, mask, v, sec});
    cfg_write(3'd0, 32'(n) | 32'h20);
    if (n < 20) begin
      m_lo[n] = lo; m_hi[n] = hi; m_il[n] = il; m_ih[n] = ih;
      m_sec[n] = sec; m_v[n] = v; m_mask[n] = mask; m_res[n] = res;
    end
  endtask

  function automatic bit exp_rej(int pg, int id, int port, bit sec);
    if (port >= 10) return 1'b1;
    for (int r = 0; r < 20; r++)
      if (m_v[r] && pg >= m_lo[r] && pg <= m_hi[r] && id >= m_il[r] && id <= m_ih[r]
          && m_mask[r][port] && (sec ? m_sec[r][0] : m_sec[r][1]))
        return m_res[r];
    return m_dflt[port];
  endfunction

  task automatic probe(string tag, int pg, int id, int port, bit sec, bit exp);
    @(negedge clk);
    req_valid = 1'b1; req_page = 12'(pg); req_id = 12'(id);
    req_port = 4'(port); req_secure = sec;
    @(negedge clk);
    chk(tag, {30'd0, resp_valid, resp_reject}, {30'd0, 1'b1, exp});
    req_valid = 1'b0;
  endtask

  task automatic sweep(string tag);
    int ids[8] = '{'h000, 'h0FF, 'h100, 'h1FF, 'h200, 'h2FF, 'h7FF, 'hFFF};
    for (int mi = 0; mi < 65; mi++) begin
      for (int ii = 0; ii < 8; ii++) begin
        for (int p = 0; p < 12; p++) begin
          for (int s = 0; s < 2; s++) begin
            int pg = (mi == 64) ? 4095 : mi;
            probe(tag, pg, ids[ii], p, s[0], exp_rej(pg, ids[ii], p, s[0]));
          end
        end
      end
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int r = 0; r < 20; r++) begin
      m_v[r] = 0; m_lo[r] = 0; m_hi[r] = 0; m_il[r] = 0; m_ih[r] = 0;
      m_sec[r] = 0; m_mask[r] = 0; m_res[r] = 0;
    end
    m_dflt = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of registers and verdicts
    for (int a = 0; a < 5; a++) begin
      cfg_read(3'(a), d);
      chk("R1 reg reset", d, 32'd0);
    end
    probe("R1 accept after reset", 0, 0, 0, 1'b1, 1'b0);
    probe("R1 accept after reset", 4095, 'hFFF, 9, 1'b0, 1'b0);
    @(negedge clk);
    // R11: idle cycle gives no response and no reject
    chk("R11 idle", {30'd0, resp_valid, resp_reject}, 32'd0);

    put_rule(0, 10, 20, 'h000, 'hFFF, 2'b11, 1, 10'h3FF, 1);
    put_rule(1, 0, 40, 'h100, 'h1FF, 2'b01, 1, 10'h3FF, 0);
    put_rule(2, 5, 5, 'h000, 'hFFF, 2'b10, 1, 10'h005, 0);
    put_rule(3, 30, 63, 'h200, 'h2FF, 2'b11, 1, 10'h2AA, 0);
    put_rule(7, 0, 4095, 'h000, 'hFFF, 2'b11, 0, 10'h3FF, 1);
    put_rule(19, 0, 4095, 'h7FF, 'h7FF, 2'b11, 1, 10'h3FF, 0);

    // R3: direct staging readback, then read command on rule 2
    cfg_read(3'd1, d);
    chk("R3 span stage readback", d, 32'((4095 << 12) | 0));
    cfg_write(3'd0, 32'h42);
    cfg_read(3'd0, d);
    chk("R3 cmd readback", d, 32'h2);
    cfg_read(3'd1, d);
    chk("R3 rule2 span", d, 32'h005005);
    cfg_read(3'd2, d);
    chk("R3 rule2 idwin", d, 32'hFFF000);
    cfg_read(3'd3, d);
    chk("R3 rule2 attr", d, {18'd0, 1'b0, 10'h005, 1'b1, 2'b10});
    cfg_write(3'd0, 32'h56);
    cfg_read(3'd3, d);
    chk("R3 nonexistent rule reads zero", d, 32'd0);

    // R8: rule 0 (reject) beats rule 1 (accept) on overlap
    probe("R8 lowest rule wins", 15, 'h150, 3, 1'b1, 1'b1);
    probe("R7 accept result", 25, 'h150, 3, 1'b1, 1'b0);

    // R2: out-of-range slot numbers change nothing
    put_rule(20, 0, 4095, 'h000, 'hFFF, 2'b11, 1, 10'h3FF, 1);
    cfg_write(3'd0, 32'h3F);
    probe("R2 slot 20/31 ignored", 50, 'h000, 0, 1'b1, 1'b0);
    cfg_write(3'd0, 32'h53);
    cfg_read(3'd2, d);
    chk("R2 rule19 intact", d, 32'h7FF7FF);

    // R10: bad port index rejected with default 0
    probe("R10 port 10", 50, 'h000, 10, 1'b1, 1'b1);
    probe("R10 port 15", 50, 'h000, 15, 1'b0, 1'b1);

    sweep("R4 R5 R6 R7 R8 R9 R10 sweep default 000");

    cfg_write(3'd4, 32'h3FF);
    m_dflt = 10'h3FF;
    probe("R4 single page inside", 5, 'h900, 0, 1'b0, 1'b0);
    probe("R4 page above bound", 6, 'h900, 0, 1'b0, 1'b1);
    probe("R4 inclusive high bound", 20, 'h900, 1, 1'b1, 1'b1);
    probe("R5 id at high bound", 35, 'h1FF, 0, 1'b1, 1'b0);
    probe("R5 id past high bound", 35, 'h200, 0, 1'b1, 1'b1);
    probe("R6 non-secure blocked", 35, 'h150, 0, 1'b0, 1'b1);
    probe("R6 masked port", 5, 'h900, 1, 1'b0, 1'b1);
    sweep("R4 R5 R6 R7 R8 R9 sweep default 3FF");

    cfg_write(3'd4, 32'h155);
    m_dflt = 10'h155;
    probe("R9 default bit set", 50, 'h000, 0, 1'b1, 1'b1);
    probe("R9 default bit clear", 50, 'h000, 1, 1'b1, 1'b0);
    sweep("R9 sweep default 155");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule